// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Stage

This block is a single decimal digit of a counter. It holds one BCD digit that steps 0, 1, … 9 and then back to 0 on rising clock edges. A synchronous parallel load presets the digit. An active-low clear empties it at once, without waiting for a clock edge.

The digit advances only when two enables are both high. One is a local enable. The other is a chain enable, which also qualifies the carry output. The carry is combinational: it is high while the digit reads 9 and the chain enable is high.

Digits are cascaded by feeding each stage's carry into the chain enable of the next stage. All stages share one clock and one local enable. A higher digit then advances only on the edge where every lower digit wraps.

Top module: `decade_stage`

## Requirements
- R1: While `clr_n` is low, `digit` is 0000 and `carry_out` is 0, immediately and without a clock edge. Clear overrides both load and count.
- R2: On a rising edge with `load_n` low, `digit` takes `load_val`, regardless of either enable. A low pulse on `load_n` that does not cover a rising edge changes nothing.
- R3: On a rising edge with `load_n` high and both `chain_en` and `local_en` high, a digit from 0 to 8 increases by one.
- R4: On such a counting edge, a digit of 9 (1001) becomes 0000.
- R5: If `chain_en` or `local_en` is low at a rising edge and `load_n` is high, `digit` keeps its value. Enable pulses that do not cover a rising edge have no effect.
- R6: `carry_out` is 1 exactly when `digit` is 1001 and `chain_en` is 1. It follows `chain_en` combinationally and ignores `local_en`. This holds whether 9 was reached by counting or by loading.
- R7: The codes 1010 to 1111 can be loaded. They are held while counting is disabled, and `carry_out` stays 0 for them.
- R8: From any code 1010 to 1111, the next counting edge gives 0000.
- R9: After `clr_n` is released, `digit` stays 0000 until a rising edge that loads or counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| chain_en | input | 1 | Count enable that also qualifies the carry |
| local_en | input | 1 | Count enable with no effect on the carry |
| load_val | input | 4 | Value loaded when `load_n` is low |
| digit | output | 4 | Present digit |
| carry_out | output | 1 | High at digit 9 while `chain_en` is high |

## Verification
The clocked properties assume that `load_n`, `chain_en`, `local_en` and `load_val` are stable around each rising edge. They also assume that `clr_n` is released away from an edge. The bench meets this by changing every input only at the falling edge or a few nanoseconds after it. Mid-period pulses are used on purpose to show that pulses missing the rising edge are ignored. Random stimulus mixes loads of all sixteen codes with enable patterns and occasional clears, and a bench reference model tracks the expected digit.

// File: rtl/decade_pkg.sv
package decade_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] LAST_CODE = DIGIT_W'(9);

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } op_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] value;
    } stage_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
    import decade_pkg::*;
(
    input  logic load_n,
    input  logic chain_en,
    input  logic local_en,
    output op_e  op
);
    // load wins over counting; counting needs both enables
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (chain_en && local_en)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/decade_step.sv
module decade_step
    import decade_pkg::*;
#(
    parameter int W = DIGIT_W,
    parameter logic [W-1:0] LAST = W'(9)
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    // 9 wraps to 0; any code above 9 folds to 0 as well
    always_comb begin
        if (cur >= LAST)
            nxt = '0;
        else
            nxt = cur + W'(1);
    end
endmodule

// File: rtl/decade_carry.sv
module decade_carry
    import decade_pkg::*;
#(
    parameter int W = DIGIT_W,
    parameter logic [W-1:0] LAST = W'(9)
) (
    input  logic [W-1:0] cur,
    input  logic         chain_en,
    output logic         carry
);
    always_comb carry = chain_en && (cur == LAST);
endmodule

// File: rtl/decade_stage.sv
module decade_stage
    import decade_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               chain_en,
    input  logic               local_en,
    input  logic [DIGIT_W-1:0] load_val,
    output logic [DIGIT_W-1:0] digit,
    output logic               carry_out
);
    stage_t             st_d, st_q;
    op_e                op_w;
    logic [DIGIT_W-1:0] step_w;

    decade_ctrl u_ctrl (
        .load_n   (load_n),
        .chain_en (chain_en),
        .local_en (local_en),
        .op       (op_w)
    );

    decade_step #(.W(DIGIT_W), .LAST(LAST_CODE)) u_step (
        .cur (st_q.value),
        .nxt (step_w)
    );

    decade_carry #(.W(DIGIT_W), .LAST(LAST_CODE)) u_carry (
        .cur      (st_q.value),
        .chain_en (chain_en),
        .carry    (carry_out)
    );

    always_comb begin
        st_d = st_q;
        case (op_w)
            OP_LOAD: st_d.value = load_val;
            OP_STEP: st_d.value = step_w;
            default: st_d.value = st_q.value;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign digit = st_q.value;

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> (digit == '0 && !carry_out));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> digit == $past(load_val));

    // R3
    step_inc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && chain_en && local_en && digit < LAST_CODE)
        |=> digit == $past(digit) + DIGIT_W'(1));

    // R4 and R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && chain_en && local_en && digit >= LAST_CODE) |=> digit == '0);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(chain_en && local_en)) |=> $stable(digit));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !chain_en |-> !carry_out);

    // R7
    carry_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (digit > LAST_CODE) |-> !carry_out);
endmodule

// File: tb/decade_stage_tb.sv
module decade_stage_tb;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       chain_en = 1'b0;
    logic       local_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [3:0] digit;
    logic       carry_out;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [3:0] model = 4'd0;

    decade_stage u_dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .chain_en  (chain_en),
        .local_en  (local_en),
        .load_val  (load_val),
        .digit     (digit),
        .carry_out (carry_out)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic ldn,
                                            input logic ce, input logic le,
                                            input logic [3:0] d);
        if (!ldn)           return d;
        else if (ce && le)  return (cur >= 4'd9) ? 4'd0 : cur + 4'd1;
        else                return cur;
    endfunction

    function automatic logic ref_carry(input logic [3:0] cur, input logic ce);
        return ce && (cur == 4'd9);
    endfunction

    task automatic chk(input string req);
        logic ec;
        ec = ref_carry(model, chain_en);
        n_vec++;
        if (digit !== model || carry_out !== ec) begin
            n_bad++;
            $display("FAIL %s: digit=%0d carry=%0b expected digit=%0d carry=%0b",
                     req, digit, carry_out, model, ec);
        end
    endtask

    // drive at falling edge, let one rising edge pass, check at next falling edge
    task automatic apply(input logic ldn, input logic ce, input logic le,
                         input logic [3:0] d, input string req);
        load_n = ldn; chain_en = ce; local_en = le; load_val = d;
        @(posedge clk);
        model = ref_next(model, ldn, ce, le, d);
        @(negedge clk);
        chk(req);
    endtask

    // clear in mid period, held over an edge with load requested
    task automatic mid_clear();
        #1 clr_n = 1'b0;
        model = 4'd0;
        #1 chk("R1");
        load_n = 1'b0; load_val = 4'd7; chain_en = 1'b1; local_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1");
        clr_n = 1'b1; load_n = 1'b1; chain_en = 1'b0; local_en = 1'b0;
        #1 chk("R9");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1 clr_n = 1'b0;
        chain_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1");
        clr_n = 1'b1;
        chain_en = 1'b0;
        // R9: stays 0 across edges that neither load nor count
        apply(1'b1, 1'b1, 1'b0, 4'd5, "R9");
        apply(1'b1, 1'b0, 1'b1, 4'd5, "R9");

        // R2: load with enables off, then 9 by load gives carry (R6)
        apply(1'b0, 1'b0, 1'b0, 4'd7, "R2");
        apply(1'b0, 1'b1, 1'b0, 4'd9, "R6");
        // R3, R4: count 9 -> 0 -> 1 -> 2
        apply(1'b1, 1'b1, 1'b1, 4'd3, "R4");
        apply(1'b1, 1'b1, 1'b1, 4'd3, "R3");
        apply(1'b1, 1'b1, 1'b1, 4'd3, "R3");
        // R2: load beats counting
        apply(1'b0, 1'b1, 1'b1, 4'd7, "R2");
        apply(1'b1, 1'b1, 1'b1, 4'd0, "R3");
        apply(1'b1, 1'b1, 1'b1, 4'd0, "R6");
        // R5: paused at 9, R6: carry follows chain_en mid period
        apply(1'b1, 1'b1, 1'b0, 4'd0, "R5");
        for (int k = 0; k < 3; k++) begin
            #1 chain_en = 1'b0;
            #1 chk("R6");
            #1 chain_en = 1'b1; local_en = 1'b1;
            #0 local_en = 1'b0;
            #1 chk("R6");
        end
        apply(1'b1, 1'b1, 1'b0, 4'd0, "R5");
        apply(1'b1, 1'b1, 1'b1, 4'd0, "R4");
        // R2: load pulse that misses the edge
        #1 load_n = 1'b0; load_val = 4'd3;
        #1 load_n = 1'b1;
        apply(1'b1, 1'b0, 1'b0, 4'd3, "R2");
        // R5: enable pulse that misses the edge
        #1 chain_en = 1'b1; local_en = 1'b1;
        #1 chain_en = 1'b0; local_en = 1'b0;
        apply(1'b1, 1'b0, 1'b0, 4'd0, "R5");
        // R7, R8: every out-of-range code
        for (int c = 10; c < 16; c++) begin
            apply(1'b0, 1'b1, 1'b0, 4'(c), "R7");
            apply(1'b1, 1'b1, 1'b0, 4'(c), "R7");
            apply(1'b1, 1'b1, 1'b1, 4'(c), "R8");
        end
        // R1: clear mid period, then count from 0
        apply(1'b0, 1'b1, 1'b0, 4'd6, "R2");
        mid_clear();
        apply(1'b1, 1'b1, 1'b1, 4'd0, "R3");

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(31) == 0) begin
                mid_clear();
            end else begin
                apply($urandom_range(3) != 0, $urandom_range(3) != 0,
                      $urandom_range(3) != 0, 4'($urandom_range(15)), "R3");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule